// File: doc/BRIEF.md
# Four-Quadrant Switch Steering Logic

This block steers a single pulse-width-modulated pulse to one of three power-switch gate drivers in a bidirectional flyback converter that makes a low-frequency AC waveform. The converter has one primary switch and two secondary switches, one n-channel and one p-channel. Two polarity bits select one of four operating modes. The first is the sign of the reference waveform. The second is the sign of the error amplifier output, which shows whether the output is behind the reference or ahead of it. In the two forward modes the primary switch is pulsed, and one secondary switch then acts as a synchronous rectifier so that the transformer flux can reset. In the two reverse modes energy flows back to the input. In those modes a secondary switch is pulsed and the primary switch stays off.

The mode is captured only at the end of a switching cycle, so a pulse already in progress is never cut short or moved to a different switch. A current-limit input blanks the pulse for the rest of the current cycle. An enable input forces every driver to its off level. The p-channel driver output is active-low. All driver outputs are registered, which keeps them free of glitches.

Top module: `quad_switch_steer`

## Requirements
- R1: During reset and after reset, gd1 and gd3 are 0, gd2_n is 1 and mode_code is 2'b00.
- R2: mode_code is loaded with {ref_sign, err_sign} on a clock edge where cycle_end is 1, and it holds its value on every other edge. The codes 00, 01, 10 and 11 stand for mode 1 to mode 4. ref_sign is 1 for a negative reference, and err_sign is 1 when the output is ahead of the reference.
- R3: In mode 1 (code 00), gd1 carries the pulse, gd2 is the rectifier and gd3 stays 0.
- R4: In mode 2 (code 01), gd3 carries the pulse, gd1 stays 0 and gd2_n stays 1.
- R5: In mode 3 (code 10), gd1 carries the pulse, gd3 is the rectifier and gd2_n stays 1.
- R6: In mode 4 (code 11), gd2_n is 0 while the pulse is present, and gd1 and gd3 stay 0.
- R7: The rectifier output of the active mode turns on one cycle after the pulse falls. It stays on until the edge where cycle_end is 1, which turns it off. It never turns on in a cycle with no pulse, and it is never on together with the pulse output.
- R8: gd2 is active-low: its off level is 1 and its on level is 0.
- R9: While enable is 0, every driver output is at its off level one cycle later. The mode register and the rectifier window continue to update.
- R10: climit at 1 blanks the pulse in that cycle and in every later cycle up to and including the next cycle_end. Blanking ends the pulse, so the rectifier window starts.
- R11: Changes on ref_sign or err_sign between cycle_end edges have no effect on the driver outputs.
- R12: Every driver output is registered: a change on an input shows at the outputs one clock edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Output enable; 0 forces all drivers to off |
| pwm | input | 1 | Pulse from the PWM comparator |
| cycle_end | input | 1 | One-cycle strobe at the end of each switching period |
| climit | input | 1 | Current-limit trip; blanks the pulse until cycle_end |
| ref_sign | input | 1 | 1 when the reference is negative |
| err_sign | input | 1 | 1 when the output is ahead of the reference |
| gd1 | output | 1 | Primary switch drive, active high |
| gd2_n | output | 1 | p-channel secondary switch drive, active low |
| gd3 | output | 1 | n-channel secondary switch drive, active high |
| mode_code | output | 2 | Latched mode, 00 to 11 for modes 1 to 4 |

## Verification
Each result appears a fixed number of clock edges after the input that causes it. A pulse edge shows on its driver one edge later. The rectifier turns on at the edge where the pulse is first seen low. mode_code changes at the cycle_end edge, but the drivers follow the new mode only from the next edge. The bench changes inputs on falling clock edges and reads the outputs one falling edge after each rising edge, so every check sees exactly one register stage of delay. The directed tasks step through pulses, limit trips and polarity changes one cycle at a time and check every intermediate state, including the cycle in which the mode changes.

// File: rtl/qsteer_pkg.sv
package qsteer_pkg;

  localparam int SW_CNT = 3;        // switches: [0] primary, [1] p-channel, [2] n-channel
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_FWD_POS = 2'b00,
    MODE_REV_POS = 2'b01,
    MODE_FWD_NEG = 2'b10,
    MODE_REV_NEG = 2'b11
  } qmode_e;

  // switch that carries the pulse in each mode
  function automatic logic [SW_CNT-1:0] pulse_target(qmode_e m);
    case (m)
      MODE_FWD_POS: pulse_target = 3'b001;
      MODE_REV_POS: pulse_target = 3'b100;
      MODE_FWD_NEG: pulse_target = 3'b001;
      default:      pulse_target = 3'b010;
    endcase
  endfunction

  // switch that rectifies after the pulse (forward modes only)
  function automatic logic [SW_CNT-1:0] rect_target(qmode_e m);
    case (m)
      MODE_FWD_POS: rect_target = 3'b010;
      MODE_FWD_NEG: rect_target = 3'b100;
      default:      rect_target = 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/qsteer_mode_reg.sv
module qsteer_mode_reg
  import qsteer_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cycle_end,
  input  logic   ref_sign,
  input  logic   err_sign,
  output qmode_e mode_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode_q <= MODE_FWD_POS;
    else if (cycle_end) mode_q <= qmode_e'({ref_sign, err_sign});
  end

  // R2: the mode changes only at the end of a cycle
  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_end |=> $stable(mode_q));

  // R2: at cycle_end the two polarity bits are captured
  p_mode_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end |=> (mode_q == qmode_e'({$past(ref_sign), $past(err_sign)})));

endmodule

// File: rtl/qsteer_window.sv
module qsteer_window (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm,
  input  logic climit,
  input  logic cycle_end,
  output logic pulse_now,
  output logic rect_now
);

  logic lim_q, pwm_d, rect_q;
  logic lim_n, rect_n, fall;

  always_comb begin
    pulse_now = pwm & ~(lim_q | climit);
    fall      = pwm_d & ~pulse_now;
    lim_n     = cycle_end ? 1'b0 : (lim_q | climit);
    rect_n    = cycle_end ? 1'b0 : (rect_q | fall);
    rect_now  = rect_n & ~pulse_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q  <= 1'b0;
      pwm_d  <= 1'b0;
      rect_q <= 1'b0;
    end else begin
      lim_q  <= lim_n;
      pwm_d  <= pulse_now;
      rect_q <= rect_n;
    end
  end

  // R7: the end of a cycle closes the rectifier window
  p_rect_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_end |=> !rect_q);

  // R10: a trip blocks the pulse on the next cycle unless the cycle has just ended
  p_limit_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (climit && !cycle_end) |=> !pulse_now);

endmodule

// File: rtl/qsteer_drive.sv
module qsteer_drive
  import qsteer_pkg::*;
#(
  parameter logic [SW_CNT-1:0] ACT_LOW = 3'b010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  qmode_e            mode,
  input  logic              pulse,
  input  logic              rect,
  output logic [SW_CNT-1:0] lvl_o
);

  logic [SW_CNT-1:0] p_sel, r_sel;

  always_comb begin
    p_sel = pulse_target(mode);
    r_sel = rect_target(mode);
  end

  for (genvar i = 0; i < SW_CNT; i++) begin : g_sw
    logic on_i;
    assign on_i = enable & ((pulse & p_sel[i]) | (rect & r_sel[i]));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_o[i] <= ACT_LOW[i];
      else        lvl_o[i] <= on_i ^ ACT_LOW[i];
    end
  end

  // R9: disabling forces every driver to its off level
  p_enable_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (lvl_o == ACT_LOW));

endmodule

// File: rtl/quad_switch_steer.sv
module quad_switch_steer
  import qsteer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              pwm,
  input  logic              cycle_end,
  input  logic              climit,
  input  logic              ref_sign,
  input  logic              err_sign,
  output logic              gd1,
  output logic              gd2_n,
  output logic              gd3,
  output logic [MODE_W-1:0] mode_code
);

  localparam logic [SW_CNT-1:0] LOW_MASK = 3'b010;

  qmode_e            mode_q;
  logic              pulse_now, rect_now;
  logic [SW_CNT-1:0] lvl;

  qsteer_mode_reg u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .cycle_end (cycle_end),
    .ref_sign  (ref_sign),
    .err_sign  (err_sign),
    .mode_q    (mode_q)
  );

  qsteer_window u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwm       (pwm),
    .climit    (climit),
    .cycle_end (cycle_end),
    .pulse_now (pulse_now),
    .rect_now  (rect_now)
  );

  qsteer_drive #(.ACT_LOW(LOW_MASK)) u_drv (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .mode   (mode_q),
    .pulse  (pulse_now),
    .rect   (rect_now),
    .lvl_o  (lvl)
  );

  assign gd1       = lvl[0];
  assign gd2_n     = lvl[1];
  assign gd3       = lvl[2];
  assign mode_code = mode_q;

  // R7: no two switches conduct at once
  p_single_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({gd1, ~gd2_n, gd3}) <= 1);

  // R4 / R6: the primary switch stays off in reverse modes
  p_rev_primary_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_code[0] |=> !gd1);

  // R3: the n-channel switch is idle in mode 1
  p_mode1_gd3_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 2'b00) |=> !gd3);

  // R10: a trip keeps the primary switch off on the following edge
  p_trip_primary_r10: assert property (@(posedge clk) disable iff (!rst_n)
    climit |=> !gd1);

endmodule

// File: tb/test_quad_switch_steer.sv
module test_quad_switch_steer;

  logic clk = 1'b0;
  logic rst_n, enable, pwm, cycle_end, climit, ref_sign, err_sign;
  logic gd1, gd2_n, gd3;
  logic [1:0] mode_code;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  quad_switch_steer i_quad_switch_steer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pwm(pwm),
    .cycle_end(cycle_end), .climit(climit), .ref_sign(ref_sign),
    .err_sign(err_sign), .gd1(gd1), .gd2_n(gd2_n), .gd3(gd3),
    .mode_code(mode_code)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // expected vector: {gd1, gd2_n, gd3, mode_code}
  task automatic chk(string tag, logic [4:0] exp);
    logic [4:0] act;
    act = {gd1, gd2_n, gd3, mode_code};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic go_mode(logic r, logic e);
    ref_sign = r; err_sign = e; cycle_end = 1'b1;
    step();
    cycle_end = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; enable = 1'b0; pwm = 1'b0; cycle_end = 1'b0;
    climit = 1'b0; ref_sign = 1'b1; err_sign = 1'b1;
    step(); step();
    chk("R1 R8 in reset", 5'b01000);
    rst_n = 1'b1; enable = 1'b1;
    step();
    chk("R1 after reset, no cycle_end yet", 5'b01000);
  endtask

  task automatic t_mode_codes();
    go_mode(1'b0, 1'b1); chk("R2 code mode2", 5'b01001);
    go_mode(1'b1, 1'b0); chk("R2 code mode3", 5'b01010);
    go_mode(1'b1, 1'b1); chk("R2 code mode4", 5'b01011);
    ref_sign = 1'b0; err_sign = 1'b0;
    step(); chk("R2 hold without cycle_end", 5'b01011);
    go_mode(1'b0, 1'b0); chk("R2 code mode1", 5'b01000);
  endtask

  task automatic t_mode1();
    go_mode(1'b0, 1'b0);
    pwm = 1'b1; step(); chk("R3 R12 gd1 pulse", 5'b11000);
    step(); chk("R3 gd1 pulse held", 5'b11000);
    pwm = 1'b0; step(); chk("R7 R8 gd2 rectifier low", 5'b00000);
    step(); chk("R7 rectifier held", 5'b00000);
    cycle_end = 1'b1; step(); cycle_end = 1'b0;
    chk("R7 rectifier ends at cycle_end", 5'b01000);
  endtask

  task automatic t_mode2();
    go_mode(1'b0, 1'b1);
    pwm = 1'b1; step(); chk("R4 gd3 pulse", 5'b01101);
    pwm = 1'b0; step(); chk("R4 no rectifier", 5'b01001);
    cycle_end = 1'b1; step(); cycle_end = 1'b0;
  endtask

  task automatic t_mode3();
    go_mode(1'b1, 1'b0);
    pwm = 1'b1; step(); chk("R5 gd1 pulse", 5'b11010);
    pwm = 1'b0; step(); chk("R5 R7 gd3 rectifier", 5'b01110);
    cycle_end = 1'b1; step(); cycle_end = 1'b0;
    chk("R5 R7 rectifier closed", 5'b01010);
  endtask

  task automatic t_mode4();
    go_mode(1'b1, 1'b1);
    pwm = 1'b1; step(); chk("R6 R8 gd2_n pulse low", 5'b00011);
    pwm = 1'b0; step(); chk("R6 no rectifier", 5'b01011);
    cycle_end = 1'b1; step(); cycle_end = 1'b0;
  endtask

  task automatic t_no_pulse();
    go_mode(1'b0, 1'b0);
    for (int i = 0; i < 3; i++) step();
    chk("R7 no window without pulse", 5'b01000);
  endtask

  task automatic t_hold_mid();
    go_mode(1'b0, 1'b0);
    pwm = 1'b1; step(); chk("R11 pulse start", 5'b11000);
    ref_sign = 1'b1; err_sign = 1'b1;
    step(); chk("R11 polarity change ignored", 5'b11000);
    pwm = 1'b0; step(); chk("R11 mode1 rectifier kept", 5'b00000);
    cycle_end = 1'b1; step(); cycle_end = 1'b0;
    chk("R2 R11 new mode at cycle_end", 5'b01011);
    pwm = 1'b1; step(); chk("R6 R11 new mode pulse", 5'b00011);
    pwm = 1'b0; cycle_end = 1'b1; step(); cycle_end = 1'b0;
  endtask

  task automatic t_climit();
    go_mode(1'b0, 1'b0);
    pwm = 1'b1; step(); chk("R10 pulse before trip", 5'b11000);
    climit = 1'b1; step(); climit = 1'b0;
    chk("R10 trip blanks, rectifier starts", 5'b00000);
    step(); chk("R10 blank held after trip", 5'b00000);
    pwm = 1'b0; cycle_end = 1'b1; step(); cycle_end = 1'b0;
    chk("R10 cycle_end clears", 5'b01000);
    pwm = 1'b1; step(); chk("R10 next cycle pulses again", 5'b11000);
    pwm = 1'b0; step();
    cycle_end = 1'b1; step(); cycle_end = 1'b0;
  endtask

  task automatic t_enable();
    go_mode(1'b0, 1'b0);
    enable = 1'b0; pwm = 1'b1; step(); chk("R9 pulse gated", 5'b01000);
    pwm = 1'b0; step(); chk("R9 rectifier gated", 5'b01000);
    enable = 1'b1; step(); chk("R9 window runs while disabled", 5'b00000);
    enable = 1'b0; ref_sign = 1'b0; err_sign = 1'b1; cycle_end = 1'b1;
    step(); cycle_end = 1'b0;
    chk("R9 mode updates while disabled", 5'b01001);
    pwm = 1'b1; step(); chk("R9 mode2 pulse gated", 5'b01001);
    pwm = 1'b0; enable = 1'b1; step();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_mode_codes();
    t_mode1();
    t_mode2();
    t_mode3();
    t_mode4();
    t_no_pulse();
    t_hold_mid();
    t_climit();
    t_enable();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule